// File: doc/BRIEF.md
# Integer Multiply Stage

This block is the multiply step of a 64-bit integer pipeline. Each operation carries two 64-bit operands, a two-bit operation code, a flag that selects 32-bit operation and a flag that selects signed operation. It returns a 64-bit result and a two-bit overflow field. There are three operations. The low operation returns the low part of the product. The high-word operation returns the upper 32 bits of a 32x32 product. The high-doubleword operation returns the upper 64 bits of a 64x64 product.

Signed products are formed from unsigned magnitudes. Each operand's sign bit is bit 31 in 32-bit mode and bit 63 in 64-bit mode. The product of the magnitudes is negated when the two signs differ. The unit is a two-stage pipeline with a valid/ready handshake. The first stage prepares the magnitudes and the negate decision. The second stage multiplies, negates, shapes the result and computes overflow. Both stages stall together when the output is held.

Top module: `imul_stage`

## Requirements
- R1: With op code 1 (high word), the result carries bits 63:32 of the 64-bit product of the operands' low 32-bit words, in both result bits 63:32 and result bits 31:0.
- R2: With the signed flag set, the sign bit is bit 31 in 32-bit mode and bit 63 in 64-bit mode. The product equals the magnitude product, negated exactly when the two signs differ. With the flag clear, both operands are read as unsigned.
- R3: With op code 2 (high doubleword) in 64-bit mode, the result is bits 127:64 of the 128-bit product, in signed and in unsigned form.
- R4: With op code 0 (low) in 32-bit mode, the result is the full 64-bit product of the two low 32-bit words, in signed and in unsigned form.
- R5: With op code 0 in 32-bit mode, overflow is set when product bits 63:31 are neither all zeros nor all ones. The test uses the final, possibly negated, product.
- R6: With op code 0 in 64-bit mode and the signed flag set, the result is bits 63:0 of the 128-bit signed product.
- R7: With op code 0 in 64-bit mode, overflow is set when product bits 127:63 are neither all zeros nor all ones.
- R8: Both bits of `out_ov` always carry the same overflow flag.
- R9: For op codes 1 and 2, `out_ov` is 2'b00.
- R10: In 32-bit mode, operand bits 63:32 change neither the result nor `out_ov`.
- R11: An operation accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after the second following edge.
- R12: While `out_valid` is high and `out_ready` is low, the result and overflow stay stable and `in_ready` is low. A stalled output and a full first stage both deliver, in order, once `out_ready` rises.
- R13: Reset (`rst_n` low) clears `out_valid` and discards any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Stage can accept an operation this cycle |
| in_op | input | 2 | 0 low, 1 high word, 2 high doubleword (3 behaves as low) |
| in_mode32 | input | 1 | 32-bit operation |
| in_signed | input | 1 | Signed operands |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Shaped result |
| out_ov | output | 2 | Overflow flag, duplicated |

## Verification
The hardest case is a stalled output that meets a full first stage. The bench holds `out_ready` low while a second operation enters behind the first. Both must then stay frozen for several cycles, with `in_ready` low. When `out_ready` rises, each result must emerge, in order, one cycle apart. The bench compares every result and overflow value against a reference product. That product is built from sign- or zero-extended operands in a 128-bit multiply, not from magnitudes, so it checks the negate path independently.

// File: rtl/imul_pkg.sv
package imul_pkg;

    typedef enum logic [1:0] {
        IMUL_LO    = 2'd0,
        IMUL_HI_W  = 2'd1,
        IMUL_HI_D  = 2'd2,
        IMUL_RSVD  = 2'd3
    } imul_op_e;

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd,
    input  logic            mode32,
    input  logic            sgn,
    output logic [XLEN-1:0] mag,
    output logic            negative
);
    localparam int HALF = XLEN / 2;

    logic [HALF-1:0] low_word;

    always_comb begin
        low_word = opnd[HALF-1:0];
        negative = sgn & (mode32 ? opnd[HALF-1] : opnd[XLEN-1]);
        if (mode32) begin
            mag = {{HALF{1'b0}}, (negative ? (~low_word + 1'b1) : low_word)};
        end else begin
            mag = negative ? (~opnd + 1'b1) : opnd;
        end
    end

endmodule

// File: rtl/imul_product_shaper.sv
module imul_product_shaper
    import imul_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int OV_COPIES = 2
) (
    input  logic [XLEN-1:0]      mag_a,
    input  logic [XLEN-1:0]      mag_b,
    input  logic                 negate,
    input  imul_op_e             op,
    input  logic                 mode32,
    output logic [XLEN-1:0]      result,
    output logic [OV_COPIES-1:0] ov
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    logic [PW-1:0]   prod_mag;
    logic [PW-1:0]   prod;
    logic [HALF:0]   win_w;
    logic [XLEN:0]   win_d;
    logic            flag;

    always_comb begin
        prod_mag = PW'(mag_a) * PW'(mag_b);
        prod     = negate ? (~prod_mag + 1'b1) : prod_mag;
        win_w    = prod[XLEN-1:HALF-1];
        win_d    = prod[PW-1:XLEN-1];
        flag     = 1'b0;
        result   = prod[XLEN-1:0];
        case (op)
            IMUL_HI_W: result = {prod[XLEN-1:HALF], prod[XLEN-1:HALF]};
            IMUL_HI_D: result = prod[PW-1:XLEN];
            default: begin
                result = prod[XLEN-1:0];
                if (mode32) flag = (|win_w) & ~(&win_w);
                else        flag = (|win_d) & ~(&win_d);
            end
        endcase
    end

    for (genvar g = 0; g < OV_COPIES; g++) begin : g_ov
        assign ov[g] = flag;
    end

endmodule

// File: rtl/imul_stage.sv
module imul_stage
    import imul_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int OV_COPIES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_op,
    input  logic                 in_mode32,
    input  logic                 in_signed,
    input  logic [XLEN-1:0]      in_a,
    input  logic [XLEN-1:0]      in_b,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [XLEN-1:0]      out_result,
    output logic [OV_COPIES-1:0] out_ov
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            valid;
        imul_op_e        op;
        logic            mode32;
        logic            neg;
        logic [XLEN-1:0] ma;
        logic [XLEN-1:0] mb;
    } prep_stage_t;

    typedef struct packed {
        logic                 valid;
        logic [XLEN-1:0]      res;
        logic [OV_COPIES-1:0] ov;
    } out_stage_t;

    typedef struct packed {
        prep_stage_t p;
        out_stage_t  o;
    } pipe_t;

    pipe_t state_d, state_q;

    logic [XLEN-1:0]      mag_a_w, mag_b_w;
    logic                 neg_a_w, neg_b_w;
    logic [XLEN-1:0]      shaped_w;
    logic [OV_COPIES-1:0] ov_w;
    logic                 advance;

    imul_operand_prep #(.XLEN(XLEN)) u_prep_a (
        .opnd(in_a), .mode32(in_mode32), .sgn(in_signed),
        .mag(mag_a_w), .negative(neg_a_w)
    );

    imul_operand_prep #(.XLEN(XLEN)) u_prep_b (
        .opnd(in_b), .mode32(in_mode32), .sgn(in_signed),
        .mag(mag_b_w), .negative(neg_b_w)
    );

    imul_product_shaper #(.XLEN(XLEN), .OV_COPIES(OV_COPIES)) u_shape (
        .mag_a(state_q.p.ma), .mag_b(state_q.p.mb), .negate(state_q.p.neg),
        .op(state_q.p.op), .mode32(state_q.p.mode32),
        .result(shaped_w), .ov(ov_w)
    );

    always_comb begin
        state_d = state_q;
        advance = !(state_q.o.valid && !out_ready);
        if (advance) begin
            state_d.p.valid = in_valid;
            if (in_valid) begin
                state_d.p.op     = imul_op_e'(in_op);
                state_d.p.mode32 = in_mode32;
                state_d.p.neg    = neg_a_w ^ neg_b_w;
                state_d.p.ma     = mag_a_w;
                state_d.p.mb     = mag_b_w;
            end
            state_d.o.valid = state_q.p.valid;
            if (state_q.p.valid) begin
                state_d.o.res = shaped_w;
                state_d.o.ov  = ov_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign in_ready   = advance;
    assign out_valid  = state_q.o.valid;
    assign out_result = state_q.o.res;
    assign out_ov     = state_q.o.ov;

    // R12: stalled output is frozen
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ov));

    // R11: accepted operation reaches the first stage after one edge
    a_r11_enter_prep: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> state_q.p.valid);

    // R11: first stage reaches the output after the next advancing edge
    a_r11_reach_out: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.p.valid && in_ready |=> out_valid);

    // R9: high operations leave the overflow field clear
    a_r9_no_overflow_high: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.p.valid && in_ready && state_q.p.op inside {IMUL_HI_W, IMUL_HI_D}
        |=> out_ov == '0);

    // R10: 32-bit magnitudes carry nothing from the upper operand half
    a_r10_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.p.valid && state_q.p.mode32
        |-> state_q.p.ma[XLEN-1:HALF] == '0 && state_q.p.mb[XLEN-1:HALF] == '0);

endmodule

// File: tb/imul_stage_bench.sv
`timescale 1ns/1ps
module imul_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'd0;
    logic        in_mode32 = 1'b0;
    logic        in_signed = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic [1:0]  out_ov;

    int compared   = 0;
    int mismatched = 0;
    int cyc        = 0;
    bit done       = 1'b0;

    imul_stage u_imul_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_mode32(in_mode32), .in_signed(in_signed),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_ov(out_ov)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [65:0] model(input logic [1:0] op, input logic m32,
                                          input logic sg, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [127:0] ea, eb, p;
        logic [32:0]  ww;
        logic [64:0]  wd;
        logic         f;
        ea = m32 ? (sg ? {{96{a[31]}}, a[31:0]} : {96'd0, a[31:0]})
                 : (sg ? {{64{a[63]}}, a} : {64'd0, a});
        eb = m32 ? (sg ? {{96{b[31]}}, b[31:0]} : {96'd0, b[31:0]})
                 : (sg ? {{64{b[63]}}, b} : {64'd0, b});
        p  = ea * eb;
        ww = p[63:31];
        wd = p[127:63];
        if (op == 2'd1) return {2'b00, p[63:32], p[63:32]};
        if (op == 2'd2) return {2'b00, p[127:64]};
        f = m32 ? (ww != '0 && ww != '1) : (wd != '0 && wd != '1);
        return {f, f, p[63:0]};
    endfunction

    task automatic issue(input string tag, input logic [1:0] op, input logic m32,
                         input logic sg, input logic [63:0] a, input logic [63:0] b);
        logic [65:0] e;
        e = model(op, m32, sg, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_mode32 = m32; in_signed = sg; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R11 no early valid"}, {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check({tag, " R11 valid after two edges"}, {63'd0, out_valid}, 64'd1);
        check({tag, " result"}, out_result, e[63:0]);
        check({tag, " overflow"}, {62'd0, out_ov}, {62'd0, e[65:64]});
        check({tag, " R8 pair"}, {63'd0, out_ov[0] ^ out_ov[1]}, 64'd0);
    endtask

    task automatic t_reset;
        check("R13 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R13 reset in_ready", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic t_hi32;
        issue("R1 hi32 unsigned", 2'd1, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        issue("R1 R2 hi32 signed mixed", 2'd1, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFD, 64'h0000_0000_0123_4567);
        issue("R9 hi32 signed both negative", 2'd1, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
    endtask

    task automatic t_hi64;
        issue("R3 hi64 unsigned", 2'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        issue("R3 R2 hi64 signed mixed", 2'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1234_5678_9ABC_DEF0);
        issue("R3 R9 hi64 signed min", 2'd2, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_lo32;
        issue("R4 R5 lo32 unsigned max", 2'd0, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        issue("R4 R2 lo32 signed negative", 2'd0, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0003);
        issue("R5 lo32 signed min squared", 2'd0, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
        issue("R5 lo32 fits exactly -2^31", 2'd0, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001);
    endtask

    task automatic t_lo64;
        issue("R6 R7 lo64 minus one squared", 2'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        issue("R7 lo64 reaches 2^63", 2'd0, 1'b0, 1'b1, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000);
        issue("R7 lo64 equals -2^63", 2'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_8000_0000);
        issue("R6 lo64 mixed", 2'd0, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF00);
    endtask

    task automatic t_upper_ignored;
        logic [63:0] r_clean, r_dirty;
        logic [1:0]  v_clean, v_dirty;
        issue("R10 clean lo32", 2'd0, 1'b1, 1'b1, 64'h0000_0000_9000_0001, 64'h0000_0000_7FFF_0003);
        r_clean = out_result; v_clean = out_ov;
        issue("R10 dirty lo32", 2'd0, 1'b1, 1'b1, 64'hDEAD_BEEF_9000_0001, 64'hA5A5_5A5A_7FFF_0003);
        r_dirty = out_result; v_dirty = out_ov;
        check("R10 result unchanged by upper bits", r_dirty, r_clean);
        check("R10 overflow unchanged by upper bits", {62'd0, v_dirty}, {62'd0, v_clean});
        issue("R10 dirty hi32", 2'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_1234_5678, 64'h5555_5555_8765_4321);
    endtask

    task automatic t_stall_collision;
        logic [65:0] ea, eb;
        ea = model(2'd2, 1'b0, 1'b0, 64'hCAFE_0000_0000_1234, 64'h0000_0000_0001_0000);
        eb = model(2'd0, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_4000_0000);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = 2'd2; in_mode32 = 1'b0; in_signed = 1'b0;
        in_a = 64'hCAFE_0000_0000_1234; in_b = 64'h0000_0000_0001_0000;
        @(negedge clk);
        check("R12 first stage accepts behind empty output", {63'd0, in_ready}, 64'd1);
        in_op = 2'd0; in_mode32 = 1'b1; in_signed = 1'b1;
        in_a = 64'h0000_0000_FFFF_FFFE; in_b = 64'h0000_0000_4000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 stalled A valid", {63'd0, out_valid}, 64'd1);
        check("R12 stalled A result", out_result, ea[63:0]);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R12 held result", out_result, ea[63:0]);
            check("R12 held valid", {63'd0, out_valid}, 64'd1);
            check("R12 in_ready low during stall", {63'd0, in_ready}, 64'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R12 B follows after release", {63'd0, out_valid}, 64'd1);
        check("R12 B result", out_result, eb[63:0]);
        check("R12 R5 B overflow", {62'd0, out_ov}, {62'd0, eb[65:64]});
        @(negedge clk);
        check("R12 drained", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'd0; in_mode32 = 1'b0; in_signed = 1'b1;
        in_a = 64'd5; in_b = 64'd7;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R13 reset clears output", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R13 in-flight operation discarded", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hi32();
        t_hi64();
        t_lo32();
        t_lo64();
        t_upper_ignored();
        t_stall_collision();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 20000);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule